// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the 16x oversampling tick that a serial transmitter and receiver use to time their bits. It does not count the system clock down by an integer. It keeps a phase accumulator and adds a programmable rate word to it on every clock. Each carry out of the accumulator gives one tick. Because the rate word is proportional to the wanted baud rate, the resolution is fine at every speed: the rate word equals baud × 2^20 / f_clk, and with a 100 MHz clock the fastest usable setting is about f_clk / 16.

Software programs the block through a small byte-wide write port. One register holds the port enable. Two registers hold the high and low bytes of the rate word. The rate bytes can only be changed while the port is disabled. The expected sequence is to wait until the line is idle, clear the enable, write the rate, and set the enable again. Clearing the enable stops the ticks and returns the accumulator to zero, so the first tick after enabling always arrives at the same phase.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the enable is clear, the rate word reads 0 and no tick is produced.
- R2: A write with address 1 loads the rate's high byte and address 2 loads its low byte. The rate output shows {high, low}. A write with address 0 sets the enable from data bit 0. A write with address 3 changes nothing.
- R3: While the enable is set, writes to either rate byte leave the rate word unchanged.
- R4: While enabled, the rate is added to a 16-bit accumulator on every clock, and tick is high for one cycle following each carry out. Over the first N cycles after enabling, the tick count is floor(N × rate / 65536).
- R5: The accumulator starts from zero on enabling. The cycle right after the enabling write carries no tick, and a rate of 0x8000 gives ticks in the 2nd and 4th cycles, so the sampled pattern is 0,1,0,1.
- R6: From the second cycle after the enable is cleared, no tick is produced. The accumulator is cleared, so re-enabling repeats the R5 phase pattern no matter what phase the accumulator held when the enable was cleared.
- R7: A rate word of zero produces no ticks while enabled.
- R8: The rate word 0xFFFF gives a tick in every cycle after the first, which is 999 ticks in the first 1000 cycles.
- R9: A rate word of round(115200 × 2^20 / 100e6) = 1208 gives 1208 ticks, within one, over 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 rate high byte, 2 rate low byte |
| wr_data | input | 8 | Write data byte |
| tick | output | 1 | Oversampling tick, one clock per accumulator carry |
| enabled | output | 1 | Current enable state |
| rate | output | 16 | Current rate word |

## Verification
The assertions assume that wr_addr and wr_data carry known values whenever wr_en is high, and that reset is held for at least one clock edge. Under that assumption the rate word cannot move while the port is enabled, and a tick cannot follow a cycle that was disabled or had a zero rate. The bench changes the inputs only on falling edges and releases the strobe after exactly one rising edge. It always clears the enable before it reprograms the rate, except in the deliberate ignored-write checks of R3. Every tick count is measured from a known enabling edge, so the exact floor formula applies.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RATE_HI = 2'd1,
        SEL_RATE_LO = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT = 0;
endpackage

// File: rtl/fbg_rate_regs.sv
module fbg_rate_regs
    import fbg_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              en,
    output logic [RATE_W-1:0] rate_word
);
    typedef struct packed {
        logic              en;
        logic [RATE_W-1:0] rate;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_CTRL:    st_d.en = wr_data[CTRL_EN_BIT];
                SEL_RATE_HI: if (!st_q.en) st_d.rate[RATE_W-1:BYTE_W] = wr_data;
                SEL_RATE_LO: if (!st_q.en) st_d.rate[BYTE_W-1:0] = wr_data;
                default:     st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en        = st_q.en;
    assign rate_word = st_q.rate;

    // R3: the rate word holds still across any edge taken while enabled
    a_r3_rate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(rate_word));
endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] inc,
    output logic              tick
);
    typedef struct packed {
        logic [RATE_W-1:0] acc;
        logic              tick;
    } acc_t;

    acc_t st_d, st_q;
    logic [RATE_W:0] sum;

    always_comb begin
        sum = {1'b0, st_q.acc} + {1'b0, inc};
        if (en) begin
            st_d.acc  = sum[RATE_W-1:0];
            st_d.tick = sum[RATE_W];
        end else begin
            st_d.acc  = '0;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R6: a disabled cycle is never followed by a tick
    a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);

    // R7: a zero rate word never yields a tick
    a_r7_zero_rate_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (en && inc == '0) |=> !tick);

    // R5: the first cycle after enabling carries no tick
    a_r5_first_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> !tick);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tick,
    output logic              enabled,
    output logic [2*BYTE_W-1:0] rate
);
    localparam int RATE_W = 2 * BYTE_W;

    logic              en_q;
    logic [RATE_W-1:0] rate_q;

    fbg_rate_regs #(
        .BYTE_W (BYTE_W),
        .RATE_W (RATE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .en        (en_q),
        .rate_word (rate_q)
    );

    fbg_phase_acc #(
        .RATE_W (RATE_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .inc   (rate_q),
        .tick  (tick)
    );

    assign enabled = en_q;
    assign rate    = rate_q;
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tick;
    logic       enabled;
    logic [15:0] rate;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int    got_q[$];
    int    exp_q[$];
    int    tol_q[$];
    string tag_q[$];
    event  obs_ev;

    frac_baud_gen u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .enabled (enabled),
        .rate    (rate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // scoreboard monitor: pops expected entries and compares observations
    initial begin
        forever begin
            @(obs_ev);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                int g, e, t, d;
                string tg;
                g  = got_q.pop_front();
                e  = exp_q.pop_front();
                t  = tol_q.pop_front();
                tg = tag_q.pop_front();
                d  = (g > e) ? g - e : e - g;
                n_tests++;
                if (d > t) begin
                    n_fail++;
                    $display("FAIL %s: got %0d expected %0d", tg, g, e);
                end
            end
        end
    end

    task automatic expect_item(input string tg, input int e, input int t);
        exp_q.push_back(e);
        tol_q.push_back(t);
        tag_q.push_back(tg);
    endtask

    task automatic observe(input int g);
        got_q.push_back(g);
        ->obs_ev;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick) c++;
        end
    endtask

    task automatic program_rate(input logic [15:0] r);
        wr(2'd0, 8'h00);
        wr(2'd1, r[15:8]);
        wr(2'd2, r[7:0]);
        wr(2'd0, 8'h01);
    endtask

    task automatic finish_run();
        #1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int c;
        logic [3:0] pat;
        int inc115;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_item("R1 enable", 0, 0);   observe(int'(enabled));
        expect_item("R1 rate", 0, 0);     observe(int'(rate));
        expect_item("R1 tick", 0, 0);     observe(int'(tick));

        // R2 register map
        wr(2'd1, 8'h12);
        wr(2'd2, 8'h34);
        expect_item("R2 rate bytes", 16'h1234, 0); observe(int'(rate));
        wr(2'd3, 8'hFF);
        expect_item("R2 unused address", 16'h1234, 0); observe(int'(rate));

        // R5 deterministic first phase with 0x8000
        wr(2'd1, 8'h80);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h01);
        expect_item("R2 enable bit", 1, 0); observe(int'(enabled));
        pat = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pat = {pat[2:0], tick};
        end
        expect_item("R5 phase pattern", 4'b0101, 0); observe(int'(pat));

        // R3 rate writes ignored while enabled
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hFF);
        expect_item("R3 rate frozen", 16'h8000, 0); observe(int'(rate));

        // R6 disable stops ticks, re-enable restarts phase
        @(negedge clk);
        wr(2'd0, 8'h00);
        expect_item("R6 enable cleared", 0, 0); observe(int'(enabled));
        count_ticks(100, c);
        expect_item("R6 no ticks disabled", 0, 0); observe(c);
        wr(2'd0, 8'h01);
        pat = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pat = {pat[2:0], tick};
        end
        expect_item("R6 restart phase", 4'b0101, 0); observe(int'(pat));

        // R7 zero rate
        program_rate(16'h0000);
        count_ticks(300, c);
        expect_item("R7 zero rate", 0, 0); observe(c);

        // R8 maximum rate word
        program_rate(16'hFFFF);
        count_ticks(1000, c);
        expect_item("R8 max rate", 999, 0); observe(c);

        // R4 accumulation under several rate words
        program_rate(16'h1000);
        count_ticks(1000, c);
        expect_item("R4 rate 0x1000", (1000 * 4096) / 65536, 0); observe(c);
        program_rate(16'h0003);
        count_ticks(50000, c);
        expect_item("R4 rate 3", (50000 * 3) / 65536, 0); observe(c);

        // R9 115200 baud setting over a full 2^16 window
        inc115 = int'((longint'(115200) * 64'd1048576 + 64'd50000000) / 64'd100000000);
        expect_item("R9 computed word", 1208, 0); observe(inc115);
        program_rate(inc115[15:0]);
        count_ticks(65536, c);
        expect_item("R9 average rate", inc115, 1); observe(c);

        done = 1'b1;
        finish_run();
    end
endmodule